// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block is the target side of a three-wire control port. It gives an off-chip controller read and write access to a bank of 8-bit configuration registers. The wires are an active-low select, a serial clock and one data line. The controller drives that data line during the command and write data. The block drives it during read data, so the line changes direction in the middle of a read frame. The block itself drives no pad. It provides the data value and an output enable for a pad buffer, and it takes the pad's input value back in.

A frame opens when select goes low. The first 16 bits form a header:
- a read/write flag;
- three reserved bits, which must be zero;
- a 12-bit register address.

Eight data bits follow. On a write, the block shifts the data in and updates the addressed register once the last bit has arrived. On a read, it captures the addressed register when the header completes and shifts that byte out on the falling serial-clock edges. The controller then samples each bit on the following rising edge.

All three serial inputs are brought into the system clock domain through synchronizers, and edges are detected there. The register contents are presented in parallel to the rest of the chip on `cfg_q`.

Top module: `ser3w_target`

## Requirements
- R1: While `rst` is high, and after it is released, every register reads as zero and `sdio_oe` is low.
- R2: A frame starts when `sel_n` falls. Bits are sampled on rising `sclk`, most significant first. Header bit 15 is the direction flag (1 = read, 0 = write), bits 14..12 are reserved, and bits 11..0 are the register address.
- R3: In a write frame, the 8 bits after the header (MSB first) become the new register value. `cfg_q` changes on the 4th rising `clk` edge after the 24th `sclk` rise reaches the input pin, and nothing else ever changes a register.
- R4: In a read frame, the register byte is shifted out MSB first. Each bit is launched on a falling `sclk` edge and is valid at the next rising edge. `sdio_oe` rises on the 3rd `clk` edge after the falling `sclk` edge that follows the 16th rise. It falls on the 3rd `clk` edge after the 24th rise, and it is low at all other times.
- R5: A read frame never modifies any register, whatever the data line carries during its data phase.
- R6: A frame with nonzero reserved bits 14..12 writes nothing if it is a write, and returns 0x00 if it is a read.
- R7: Addresses at or above `NUM_REGS` hold nothing. A write to such an address changes no register, and no register aliases it through truncated address bits. A read of such an address returns 0x00.
- R8: If `sel_n` rises before the 24th `sclk` rise, the frame is abandoned. No register changes, `sdio_oe` falls on the 3rd `clk` edge after the select rise, and the next frame starts from a fresh bit count.
- R9: After the 24th rise, further `sclk` edges within the same frame have no effect.
- R10: If the `sel_n` rise and the 24th `sclk` rise change at the pins in the same `clk` interval, the select rise wins and the write is dropped.
- R11: `sclk` and data activity while `sel_n` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low frame select from the controller |
| sclk | input | 1 | Serial clock from the controller |
| sdio_in | input | 1 | Value seen on the shared data pad |
| sdio_out | output | 1 | Read bit to drive onto the data pad |
| sdio_oe | output | 1 | Pad driver enable; high only during read data |
| cfg_q | output | NUM_REGS*8 | All registers, register r at bits r*8+7..r*8 |

## Verification
The delicate coincidence is the frame commit and the frame abort arriving in the same sampling cycle: the 24th serial-clock rise and the select release. The bench changes both pins at the same instant, so both pass through synchronizers of equal depth and meet in one cycle. The per-clock register-image comparison then shows whether the write was dropped, and a later read of the same register confirms it. The mid-read abort is also covered: it is judged by the enable falling exactly three cycles after select rises, and by the following frame decoding correctly from a fresh count.

// File: rtl/ser3w_pkg.sv
package ser3w_pkg;

    // Frame geometry; fixed by the protocol
    localparam int unsigned HDR_BITS   = 16;
    localparam int unsigned DATA_BITS  = 8;
    localparam int unsigned ADDR_BITS  = 12;
    localparam int unsigned RSV_BITS   = 3;
    localparam int unsigned FRAME_BITS = HDR_BITS + DATA_BITS;
    localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);

    typedef logic [ADDR_BITS-1:0] addr_t;
    typedef logic [DATA_BITS-1:0] data_t;
    typedef logic [CNT_W-1:0]     cnt_t;

    // Header word, first bit on the wire is rd
    typedef struct packed {
        logic                rd;
        logic [RSV_BITS-1:0] rsv;
        addr_t               addr;
    } hdr_t;

    typedef enum logic [1:0] {
        PH_HDR   = 2'd0,
        PH_WDATA = 2'd1,
        PH_RDATA = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;

    // One-cycle register update request
    typedef struct packed {
        logic  stb;
        addr_t addr;
        data_t data;
    } wr_req_t;

    function automatic logic hdr_legal(hdr_t h);
        return (h.rsv == '0);
    endfunction

    function automatic cnt_t cnt_of(int unsigned n);
        return cnt_t'(n);
    endfunction

endpackage

// File: rtl/ser3w_sync.sv
module ser3w_sync #(
    parameter int unsigned WIDTH     = 3,
    parameter int unsigned STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= {STAGES{RESET_VAL[b]}};
                end else begin
                    chain <= {chain[STAGES-2:0], d[b]};
                end
            end
            assign q[b] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/ser3w_frame.sv
module ser3w_frame
    import ser3w_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sel_act,
    input  logic    sclk_s,
    input  logic    sdi_s,
    input  data_t   rd_data,
    output addr_t   rd_addr,
    output wr_req_t wr_req,
    output logic    sdo,
    output logic    sdo_oe
);

    logic                 sclk_q;
    logic                 rise;
    logic                 fall;
    cnt_t                 bit_cnt;
    phase_e               phase;
    hdr_t                 hdr_sh;
    hdr_t                 hdr_next;
    logic [DATA_BITS-2:0] dat_sh;
    data_t                dat_next;
    data_t                rd_buf;

    assign rise     = sclk_s & ~sclk_q;
    assign fall     = ~sclk_s & sclk_q;
    assign hdr_next = hdr_t'({hdr_sh[HDR_BITS-2:0], sdi_s});
    assign dat_next = {dat_sh, sdi_s};
    assign rd_addr  = hdr_next.addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            bit_cnt <= '0;
            phase   <= PH_HDR;
            hdr_sh  <= '0;
            dat_sh  <= '0;
            rd_buf  <= '0;
            wr_req  <= '0;
            sdo     <= 1'b0;
            sdo_oe  <= 1'b0;
        end else begin
            sclk_q     <= sclk_s;
            wr_req.stb <= 1'b0;
            if (!sel_act) begin
                // idle or abandoned frame: back to a fresh count
                bit_cnt <= '0;
                phase   <= PH_HDR;
                sdo_oe  <= 1'b0;
                sdo     <= 1'b0;
            end else if (rise) begin
                unique case (phase)
                    PH_HDR: begin
                        hdr_sh  <= hdr_next;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == cnt_of(HDR_BITS - 1)) begin
                            if (hdr_next.rd) begin
                                phase  <= PH_RDATA;
                                rd_buf <= hdr_legal(hdr_next) ? rd_data : '0;
                            end else begin
                                phase  <= PH_WDATA;
                            end
                        end
                    end
                    PH_WDATA: begin
                        dat_sh  <= dat_next[DATA_BITS-2:0];
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == cnt_of(FRAME_BITS - 1)) begin
                            phase <= PH_DONE;
                            if (hdr_legal(hdr_sh) && !hdr_sh.rd) begin
                                wr_req.stb  <= 1'b1;
                                wr_req.addr <= hdr_sh.addr;
                                wr_req.data <= dat_next;
                            end
                        end
                    end
                    PH_RDATA: begin
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == cnt_of(FRAME_BITS - 1)) begin
                            phase  <= PH_DONE;
                            sdo_oe <= 1'b0;
                        end
                    end
                    default: begin
                        // frame complete: extra edges are ignored
                    end
                endcase
            end else if (fall && phase == PH_RDATA) begin
                sdo_oe <= 1'b1;
                sdo    <= rd_buf[DATA_BITS-1];
                rd_buf <= {rd_buf[DATA_BITS-2:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/ser3w_regbank.sv
module ser3w_regbank
    import ser3w_pkg::*;
#(
    parameter int unsigned NUM_REGS = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  wr_req_t                 wr_req,
    input  addr_t                   rd_addr,
    output data_t                   rd_data,
    output logic [NUM_REGS*DATA_BITS-1:0] cfg_q
);

    data_t regs [NUM_REGS];

    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs[r] <= '0;
                end else if (wr_req.stb && wr_req.addr == addr_t'(r)) begin
                    regs[r] <= wr_req.data;
                end
            end
            assign cfg_q[r*DATA_BITS +: DATA_BITS] = regs[r];
        end
    endgenerate

    // full-address decode: no aliasing above NUM_REGS
    always_comb begin
        rd_data = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (rd_addr == addr_t'(r)) begin
                rd_data = regs[r];
            end
        end
    end

endmodule

// File: rtl/ser3w_target.sv
module ser3w_target
    import ser3w_pkg::*;
#(
    parameter int unsigned NUM_REGS    = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          sel_n,
    input  logic                          sclk,
    input  logic                          sdio_in,
    output logic                          sdio_out,
    output logic                          sdio_oe,
    output logic [NUM_REGS*DATA_BITS-1:0] cfg_q
);

    localparam int unsigned PIN_N = 3;
    localparam int unsigned P_SEL = 2;
    localparam int unsigned P_CLK = 1;
    localparam int unsigned P_DAT = 0;

    logic [PIN_N-1:0] pins_s;
    logic             sel_act;
    addr_t            rd_addr;
    data_t            rd_data;
    wr_req_t          wr_req;

    ser3w_sync #(
        .WIDTH     (PIN_N),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (3'b100)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sel_n, sclk, sdio_in}),
        .q   (pins_s)
    );

    assign sel_act = ~pins_s[P_SEL];

    ser3w_frame u_frame (
        .clk     (clk),
        .rst     (rst),
        .sel_act (sel_act),
        .sclk_s  (pins_s[P_CLK]),
        .sdi_s   (pins_s[P_DAT]),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_req  (wr_req),
        .sdo     (sdio_out),
        .sdo_oe  (sdio_oe)
    );

    ser3w_regbank #(
        .NUM_REGS (NUM_REGS)
    ) u_regbank (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (wr_req),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cfg_q   (cfg_q)
    );

endmodule

// File: rtl/ser3w_target_chk.sv
module ser3w_target_chk
    import ser3w_pkg::*;
#(
    parameter int unsigned NUM_REGS = 16
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          sel_act,
    input logic                          sdio_oe,
    input logic                          wr_stb,
    input cnt_t                          cnt,
    input logic [NUM_REGS*DATA_BITS-1:0] cfg_q
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!sdio_oe && cnt == '0));

    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(cfg_q));

    // R3
    wr_single_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R8
    oe_needs_select_chk: assert property (@(posedge clk) disable iff (rst)
        !sel_act |=> !sdio_oe);

    // R5
    no_drive_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        !(sdio_oe && wr_stb));

    // R4
    oe_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sdio_oe) |-> (cnt == cnt_of(HDR_BITS)));

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= cnt_of(FRAME_BITS));

endmodule

bind ser3w_target ser3w_target_chk #(
    .NUM_REGS (NUM_REGS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sel_act (sel_act),
    .sdio_oe (sdio_oe),
    .wr_stb  (wr_req.stb),
    .cnt     (u_frame.bit_cnt),
    .cfg_q   (cfg_q)
);

// File: tb/ser3w_target_bench.sv
`timescale 1ns/1ps
module ser3w_target_bench;

    localparam int NUM_REGS = 16;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    sel_n = 1'b1;
    logic                    sclk = 1'b0;
    logic                    sdio_in = 1'b0;
    logic                    sdio_out;
    logic                    sdio_oe;
    logic [NUM_REGS*8-1:0]   cfg_q;

    int errors = 0;
    int checks = 0;
    bit running = 0;
    string cur_req = "R1";

    // behavioural reference state
    int   exp_reg [NUM_REGS];
    logic exp_oe = 1'b0;
    int   oe_evt = -1;
    bit   wr_pend = 0;
    int   wr_addr;
    int   wr_data;

    always #2.5 clk = ~clk;

    ser3w_target #(.NUM_REGS(NUM_REGS)) u_ser3w_target (
        .clk(clk), .rst(rst), .sel_n(sel_n), .sclk(sclk), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .cfg_q(cfg_q)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-clock comparison against the reference image
    always @(posedge clk) begin
        #1;
        if (running) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                check(cfg_q[r*8 +: 8] === exp_reg[r][7:0], cur_req, "cfg_q byte",
                      int'(cfg_q[r*8 +: 8]), exp_reg[r]);
            end
            check(sdio_oe === exp_oe, cur_req, "sdio_oe", int'(sdio_oe), int'(exp_oe));
        end
    end

    // one half period of sclk: 8 clocks, pending model events applied in place
    task automatic half(input logic s, input logic d, input logic sn);
        sclk = s; sdio_in = d; sel_n = sn;
        for (int k = 1; k <= 8; k++) begin
            @(posedge clk);
            if (k == 3 && oe_evt >= 0) begin exp_oe = oe_evt[0]; oe_evt = -1; end
            if (k == 4 && wr_pend) begin exp_reg[wr_addr] = wr_data; wr_pend = 0; end
        end
        @(negedge clk);
    endtask

    task automatic frame(input bit rd, input logic [2:0] rsv, input logic [11:0] addr,
                         input logic [7:0] wdata, input int nbits, input bit clash,
                         input int extra);
        logic [23:0] word;
        int          exp_rd;
        word   = {rd, rsv, addr, wdata};
        exp_rd = (rsv == 3'b0 && addr < NUM_REGS) ? exp_reg[addr] : 0;
        half(1'b0, word[23], 1'b0);
        for (int i = 0; i < nbits; i++) begin
            if (rd && i >= 16) begin
                check(sdio_oe === 1'b1, cur_req, "oe at sample", int'(sdio_oe), 1);
                check(sdio_out === exp_rd[23 - i], cur_req, "read bit",
                      int'(sdio_out), int'(exp_rd[23 - i]));
            end
            if (clash && i == nbits - 1) begin
                oe_evt = 0;
                half(1'b1, word[23 - i], 1'b1);
                half(1'b0, 1'b0, 1'b1);
                return;
            end
            if (i == 23) begin
                if (rd) oe_evt = 0;
                else if (rsv == 3'b0 && addr < NUM_REGS) begin
                    wr_pend = 1; wr_addr = addr; wr_data = wdata;
                end
            end
            half(1'b1, word[23 - i], 1'b0);
            if (rd && i >= 15 && i <= 22) oe_evt = 1;
            half(1'b0, (i < 23) ? word[22 - i] : 1'b1, 1'b0);
        end
        for (int e = 0; e < extra; e++) begin
            half(1'b1, 1'b1, 1'b0);
            half(1'b0, 1'b0, 1'b0);
        end
        oe_evt = 0;
        half(1'b0, 1'b0, 1'b1);
        half(1'b0, 1'b0, 1'b1);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        for (int r = 0; r < NUM_REGS; r++) exp_reg[r] = 0;
        repeat (6) @(negedge clk);
        // R1: state during reset
        check(sdio_oe === 1'b0, "R1", "oe in reset", int'(sdio_oe), 0);
        check(cfg_q === '0, "R1", "cfg in reset", int'(cfg_q[31:0]), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(cfg_q === '0, "R1", "cfg after reset", int'(cfg_q[31:0]), 0);
        running = 1;

        // R2 R3: writes, MSB first, boundary registers
        cur_req = "R3";
        frame(0, 3'b000, 12'd3, 8'hA5, 24, 0, 0);
        frame(0, 3'b000, 12'd15, 8'h3C, 24, 0, 0);
        frame(0, 3'b000, 12'd0, 8'h81, 24, 0, 0);

        // R4 R2: reads of written and untouched registers
        cur_req = "R4";
        frame(1, 3'b000, 12'd3, 8'h00, 24, 0, 0);
        frame(1, 3'b000, 12'd15, 8'h00, 24, 0, 0);
        frame(1, 3'b000, 12'd7, 8'h00, 24, 0, 0);

        // R5: read with data line high during data phase
        cur_req = "R5";
        frame(1, 3'b000, 12'd0, 8'hFF, 24, 0, 0);

        // R6: reserved bits nonzero
        cur_req = "R6";
        frame(0, 3'b010, 12'd5, 8'hFF, 24, 0, 0);
        frame(1, 3'b001, 12'd3, 8'h00, 24, 0, 0);

        // R7: out-of-range addresses, no aliasing
        cur_req = "R7";
        frame(0, 3'b000, 12'h013, 8'h11, 24, 0, 0);
        frame(0, 3'b000, 12'hFFF, 8'h22, 24, 0, 0);
        frame(1, 3'b000, 12'h810, 8'h00, 24, 0, 0);
        frame(1, 3'b000, 12'd3, 8'h00, 24, 0, 0);

        // R8: aborted write and aborted read, then a clean read
        cur_req = "R8";
        frame(0, 3'b000, 12'd3, 8'h00, 20, 0, 0);
        frame(1, 3'b000, 12'd3, 8'h00, 19, 0, 0);
        frame(1, 3'b000, 12'd3, 8'h00, 24, 0, 0);

        // R9: extra clocks after a completed write
        cur_req = "R9";
        frame(0, 3'b000, 12'd1, 8'h5A, 24, 0, 4);
        frame(1, 3'b000, 12'd1, 8'h00, 24, 0, 3);

        // R10: select release together with the 24th rise
        cur_req = "R10";
        frame(0, 3'b000, 12'd2, 8'h77, 24, 1, 0);
        frame(1, 3'b000, 12'd2, 8'h00, 24, 0, 0);

        // R11: serial activity while deselected
        cur_req = "R11";
        for (int t = 0; t < 30; t++) begin
            half(1'b1, t[0], 1'b1);
            half(1'b0, t[1], 1'b1);
        end
        frame(1, 3'b000, 12'd15, 8'h00, 24, 0, 0);

        running = 0;
        finish_run();
    end

endmodule